// File: doc/BRIEF.md
# Indexed Operand Address Sequencer

This block works out the final operand address for the indexed forms of an 8-bit processor. It handles two kinds of request. In the direct forms, an X or Y register value is added to an address taken from the instruction. In the pointer forms, a two-byte pointer is first read out of page zero. The block receives the mode code, the two operand bytes and the current X and Y values in one cycle. It drives a byte-wide read port when it needs pointer bytes. It then presents the 16-bit target address together with a one-cycle completion pulse.

The surrounding core raises `reqValid` for a cycle while `busy` is low. It waits for `done` and then uses `effAddr` for its own data access. The read port assumes memory that answers in the same cycle: `memData` must reflect `memAddr` in any cycle where `memRd` is high.

Top module: `idx_addr_seq`

## Requirements
- R1: After reset, `busy`, `done` and `memRd` are low and `effAddr` is 0x0000.
- R2: A request is taken at a rising clock edge only when `reqValid` is high and `busy` is low. Mode codes are 0 = absolute+X, 1 = absolute+Y, 2 = page-zero+X, 3 = page-zero+Y, 4 = pointer at (operand+X), and 5 = pointer at operand, plus Y. Codes 6 and 7 are ignored: `busy` stays low and `effAddr` is unchanged.
- R3: In modes 0 and 1, `effAddr` = {opHi,opLo} + index, taken modulo 0x10000. `done` is high in the cycle after acceptance, and no read is issued.
- R4: In modes 2 and 3, `effAddr` = 0x00 in the upper byte and (opLo + index) mod 256 in the lower byte. `opHi` is ignored. `done` comes in the cycle after acceptance, with no read.
- R5: In mode 4, the pointer location is p = (opLo + X) mod 256. The low byte is read from 0x00:p, and the high byte from 0x00:((p+1) mod 256). `effAddr` = {high, low}.
- R6: In mode 5, the low byte is read from 0x00:opLo and the high byte from 0x00:((opLo+1) mod 256). `effAddr` = ({high, low} + Y) mod 0x10000.
- R7: In the pointer modes, `memRd` is high in the first cycle after acceptance (low byte) and in the second cycle (high byte). `done` follows in the third cycle. `memData` is taken in the same cycle as its read strobe.
- R8: `done` lasts exactly one cycle. `effAddr` changes only as `done` rises, and it holds its value until the next completion.
- R9: A request raised while `busy` is high has no effect on the operation in progress or on its result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request strobe |
| reqMode | input | 3 | Mode code (see R2) |
| opLo | input | 8 | Low operand byte, or page-zero operand |
| opHi | input | 8 | High operand byte |
| regX | input | 8 | X register value |
| regY | input | 8 | Y register value |
| busy | output | 1 | High while a request is in progress |
| memRd | output | 1 | Pointer byte read strobe |
| memAddr | output | 16 | Pointer byte read address |
| memData | input | 8 | Read data, valid in the cycle of `memRd` |
| done | output | 1 | One-cycle completion pulse |
| effAddr | output | 16 | Resolved target address |

## Verification
The properties take two things for granted. First, the read port returns data in the same cycle as the strobe. Second, the operand and register inputs are valid only in the request cycle. The bench keeps to this by using a combinational page-zero memory with a computed pattern, and by driving operands only in the cycle `reqValid` is high, after which it changes them freely. The pointer checks rely on memory content where the pointer bytes straddle 0xFF/0x00 and where the final sum crosses 0xFFFF. Those cases are placed in the vector table on purpose.

// File: rtl/idx_seq_pkg.sv
package idx_seq_pkg;

  typedef enum logic [2:0] {
    MODE_ABS_X = 3'd0,
    MODE_ABS_Y = 3'd1,
    MODE_ZP_X  = 3'd2,
    MODE_ZP_Y  = 3'd3,
    MODE_PTR_X = 3'd4,
    MODE_PTR_Y = 3'd5
  } addrMode_t;

  // control-to-datapath strobes
  typedef struct packed {
    logic load;    // latch the request
    logic capLo;   // capture pointer low byte
    logic capHi;   // capture pointer high byte, form result
    logic addrHi;  // read port points at the high byte
  } seqStrobe_t;

  function automatic logic modeValid(input logic [2:0] m);
    return m <= 3'd5;
  endfunction

  function automatic logic modePtr(input logic [2:0] m);
    return (m == MODE_PTR_X) || (m == MODE_PTR_Y);
  endfunction

  function automatic logic modeUsesY(input logic [2:0] m);
    return (m == MODE_ABS_Y) || (m == MODE_ZP_Y) || (m == MODE_PTR_Y);
  endfunction

  function automatic logic modePage0(input logic [2:0] m);
    return (m == MODE_ZP_X) || (m == MODE_ZP_Y);
  endfunction

endpackage

// File: rtl/idx_seq_ctrl.sv
module idx_seq_ctrl
  import idx_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reqValid,
  input  logic [2:0] reqMode,
  output seqStrobe_t strobe,
  output logic       busy,
  output logic       memRd,
  output logic       done
);

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RD_LO = 2'd1,
    ST_RD_HI = 2'd2,
    ST_FIN   = 2'd3
  } seqState_t;

  seqState_t state, stateNext;
  logic accept;

  assign accept = (state == ST_IDLE) && reqValid && modeValid(reqMode);

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:  if (accept) stateNext = modePtr(reqMode) ? ST_RD_LO : ST_FIN;
      ST_RD_LO: stateNext = ST_RD_HI;
      ST_RD_HI: stateNext = ST_FIN;
      ST_FIN:   stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= stateNext;
  end

  always_comb begin
    strobe.load   = accept;
    strobe.capLo  = (state == ST_RD_LO);
    strobe.capHi  = (state == ST_RD_HI);
    strobe.addrHi = (state == ST_RD_HI);
  end

  assign busy  = (state != ST_IDLE);
  assign memRd = (state == ST_RD_LO) || (state == ST_RD_HI);
  assign done  = (state == ST_FIN);

endmodule

// File: rtl/idx_seq_dp.sv
module idx_seq_dp
  import idx_seq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  seqStrobe_t            strobe,
  input  logic [2:0]            reqMode,
  input  logic [DATA_W-1:0]     opLo,
  input  logic [DATA_W-1:0]     opHi,
  input  logic [DATA_W-1:0]     regX,
  input  logic [DATA_W-1:0]     regY,
  input  logic [DATA_W-1:0]     memData,
  output logic [2*DATA_W-1:0]   memAddr,
  output logic [2*DATA_W-1:0]   effAddr
);

  localparam int ADDR_W = 2 * DATA_W;

  logic [2:0]        modeR;
  logic [DATA_W-1:0] idxR, ptrR, loR;
  logic [ADDR_W-1:0] effR;

  logic [DATA_W-1:0] selIdx, ptrStart, ptrNext, page0Sum;
  logic [ADDR_W-1:0] directAddr, ptrWord, ptrAdd;

  assign selIdx   = modeUsesY(reqMode) ? regY : regX;
  assign ptrStart = opLo + ((reqMode == MODE_PTR_X) ? regX : DATA_W'(0));
  assign page0Sum = opLo + selIdx;
  assign ptrNext  = ptrR + DATA_W'(1);

  always_comb begin
    if (modePage0(reqMode)) directAddr = {{DATA_W{1'b0}}, page0Sum};
    else                    directAddr = {opHi, opLo} + ADDR_W'(selIdx);
  end

  assign ptrWord = {memData, loR};
  assign ptrAdd  = (modeR == MODE_PTR_Y) ? ADDR_W'(idxR) : ADDR_W'(0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      modeR <= '0;
      idxR  <= '0;
      ptrR  <= '0;
      loR   <= '0;
      effR  <= '0;
    end else begin
      if (strobe.load) begin
        modeR <= reqMode;
        idxR  <= selIdx;
        ptrR  <= ptrStart;
        if (!modePtr(reqMode)) effR <= directAddr;
      end
      if (strobe.capLo) loR  <= memData;
      if (strobe.capHi) effR <= ptrWord + ptrAdd;
    end
  end

  assign memAddr = {{DATA_W{1'b0}}, strobe.addrHi ? ptrNext : ptrR};
  assign effAddr = effR;

endmodule

// File: rtl/idx_addr_seq.sv
module idx_addr_seq
  import idx_seq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reqValid,
  input  logic [2:0]          reqMode,
  input  logic [DATA_W-1:0]   opLo,
  input  logic [DATA_W-1:0]   opHi,
  input  logic [DATA_W-1:0]   regX,
  input  logic [DATA_W-1:0]   regY,
  output logic                busy,
  output logic                memRd,
  output logic [2*DATA_W-1:0] memAddr,
  input  logic [DATA_W-1:0]   memData,
  output logic                done,
  output logic [2*DATA_W-1:0] effAddr
);

  seqStrobe_t strobe;

  idx_seq_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqMode(reqMode),
    .strobe(strobe), .busy(busy), .memRd(memRd), .done(done)
  );

  idx_seq_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .reqMode(reqMode),
    .opLo(opLo), .opHi(opHi), .regX(regX), .regY(regY),
    .memData(memData), .memAddr(memAddr), .effAddr(effAddr)
  );

endmodule

// File: rtl/idx_seq_chk.sv
module idx_seq_chk #(
  parameter int DATA_W = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                reqValid,
  input logic                busy,
  input logic                memRd,
  input logic [2*DATA_W-1:0] memAddr,
  input logic                done,
  input logic [2*DATA_W-1:0] effAddr
);

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_idle_after_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  assert_result_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(effAddr));

  assert_read_page0_R5: assert property (@(posedge clk) disable iff (!rst_n)
    memRd |-> (memAddr[2*DATA_W-1:DATA_W] == '0));

  assert_read_pair_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(memRd) |=> memRd);

  assert_read_adjacent_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (memRd && $past(memRd)) |-> (memAddr[DATA_W-1:0] == $past(memAddr[DATA_W-1:0]) + DATA_W'(1)));

  assert_read_in_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    memRd |-> busy);

  assert_start_on_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(reqValid));

endmodule

bind idx_addr_seq idx_seq_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .busy(busy),
  .memRd(memRd), .memAddr(memAddr), .done(done), .effAddr(effAddr)
);

// File: tb/sim_idx_addr_seq.sv
module sim_idx_addr_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reqValid = 1'b0;
  logic [2:0]  reqMode = '0;
  logic [7:0]  opLo = '0, opHi = '0, regX = '0, regY = '0;
  logic        busy, memRd, done;
  logic [15:0] memAddr, effAddr;
  logic [7:0]  memData;

  int nChecks = 0;
  int nFail = 0;

  always #5 clk = ~clk;

  // page-zero memory model: byte at a = a ^ 0x5A
  assign memData = memAddr[7:0] ^ 8'h5A;

  idx_addr_seq u0 (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqMode(reqMode),
    .opLo(opLo), .opHi(opHi), .regX(regX), .regY(regY),
    .busy(busy), .memRd(memRd), .memAddr(memAddr), .memData(memData),
    .done(done), .effAddr(effAddr)
  );

  // {mode, lo, hi, x, y, expected address}
  localparam int NVEC = 12;
  localparam logic [50:0] VEC [NVEC] = '{
    {3'd0, 8'h34, 8'h12, 8'h10, 8'h00, 16'h1244},  // R3 abs+X
    {3'd1, 8'hF0, 8'h12, 8'h00, 8'h20, 16'h1310},  // R3 abs+Y carry into high byte
    {3'd0, 8'hF0, 8'hFF, 8'h20, 8'h00, 16'h0010},  // R3 64K wrap
    {3'd2, 8'h80, 8'h00, 8'h05, 8'h00, 16'h0085},  // R4 page0+X
    {3'd3, 8'hF0, 8'h77, 8'h00, 8'h20, 16'h0010},  // R4 page0+Y wrap, hi ignored
    {3'd2, 8'hFF, 8'h00, 8'h01, 8'h00, 16'h0000},  // R4 wrap to 00
    {3'd4, 8'h10, 8'h00, 8'h05, 8'h00, 16'h4C4F},  // R5
    {3'd4, 8'hF0, 8'h00, 8'h0F, 8'h00, 16'h5AA5},  // R5 pointer at FF
    {3'd4, 8'hF0, 8'h00, 8'h20, 8'h00, 16'h4B4A},  // R5 operand+X wraps
    {3'd5, 8'h20, 8'h00, 8'h00, 8'h03, 16'h7B7D},  // R6
    {3'd5, 8'hFF, 8'h00, 8'h00, 8'h80, 16'h5B25},  // R6 pointer at FF
    {3'd5, 8'hA4, 8'h00, 8'h00, 8'h05, 16'h0003}   // R6 64K wrap
  };

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] m, input logic [7:0] lo, input logic [7:0] hi,
                       input logic [7:0] x, input logic [7:0] y);
    @(negedge clk);
    reqValid = 1'b1; reqMode = m; opLo = lo; opHi = hi; regX = x; regY = y;
    @(negedge clk);
    reqValid = 1'b0; opLo = 8'hEE; opHi = 8'hEE; regX = 8'hEE; regY = 8'hEE;
  endtask

  // run one request; caller's issue() has left us one cycle after acceptance
  task automatic runVec(input logic [2:0] m, input logic [7:0] lo, input logic [7:0] hi,
                        input logic [7:0] x, input logic [7:0] y, input logic [15:0] expA);
    int reads = 0;
    int lat = 1;
    logic [15:0] rdA [2];
    logic isPtr = (m == 3'd4) || (m == 3'd5);
    logic [7:0] p = (m == 3'd4) ? 8'(lo + x) : lo;
    rdA[0] = '0; rdA[1] = '0;
    issue(m, lo, hi, x, y);
    while (!done && lat < 6) begin
      if (memRd && reads < 2) begin rdA[reads] = memAddr; reads++; end
      @(negedge clk);
      lat++;
    end
    check(done == 1'b1, "R7 done seen", done, 1);
    check(lat == (isPtr ? 3 : 1), isPtr ? "R7 latency" : "R3/R4 latency", lat, isPtr ? 3 : 1);
    check(reads == (isPtr ? 2 : 0), isPtr ? "R7 read count" : "R3/R4 no reads", reads, isPtr ? 2 : 0);
    if (isPtr) begin
      check(rdA[0] == {8'h00, p}, (m == 3'd4) ? "R5 low read addr" : "R6 low read addr", rdA[0], {8'h00, p});
      check(rdA[1] == {8'h00, 8'(p + 8'd1)}, (m == 3'd4) ? "R5 high read addr" : "R6 high read addr",
            rdA[1], {8'h00, 8'(p + 8'd1)});
    end
    check(effAddr == expA, "R3/R4/R5/R6 result", effAddr, expA);
    @(negedge clk);
    check(done == 1'b0, "R8 done one cycle", done, 0);
    check(effAddr == expA, "R8 result held", effAddr, expA);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(busy == 1'b0, "R1 busy", busy, 0);
    check(done == 1'b0, "R1 done", done, 0);
    check(memRd == 1'b0, "R1 memRd", memRd, 0);
    check(effAddr == 16'h0000, "R1 effAddr", effAddr, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      runVec(VEC[i][50:48], VEC[i][47:40], VEC[i][39:32], VEC[i][31:24],
             VEC[i][23:16], VEC[i][15:0]);
    end

    // R2: invalid codes 6 and 7 are ignored
    for (int c = 6; c < 8; c++) begin
      issue(3'(c), 8'h11, 8'h22, 8'h01, 8'h01);
      check(busy == 1'b0, "R2 invalid code busy", busy, 0);
      @(negedge clk);
      check(done == 1'b0 && effAddr == 16'h0003, "R2 invalid code no result", effAddr, 16'h0003);
    end

    // R9: a second request while busy is ignored
    issue(3'd5, 8'h20, 8'h00, 8'h00, 8'h03);
    reqValid = 1'b1; reqMode = 3'd0; opLo = 8'h00; opHi = 8'h40; regX = 8'h01;
    @(negedge clk);
    reqValid = 1'b0;
    check(busy == 1'b1 && memRd == 1'b1, "R9 still reading", memRd, 1);
    @(negedge clk);
    check(done == 1'b1, "R9 original done", done, 1);
    check(effAddr == 16'h7B7D, "R9 original result", effAddr, 16'h7B7D);
    @(negedge clk);
    check(busy == 1'b0 && done == 1'b0, "R9 no second op", busy, 0);
    @(negedge clk);
    check(effAddr == 16'h7B7D, "R9 result kept", effAddr, 16'h7B7D);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

endmodule